// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a small microcontroller core. A call or an interrupt pushes the current program-counter value, and a return pops it. The top entry is always visible on `topPc`, so the core takes the return address in the same cycle in which it requests the pop. The stack has sixteen 15-bit entries. It is indexed by a 5-bit pointer whose all-ones value means empty. A pointer whose most significant bit is set after a push marks an overflow.

Overflow and underflow set sticky status flags. When the fault-reset option is on, a fault also requests a program-counter reset and empties the stack. When the option is off, the pointer keeps counting and the low four bits wrap over the entries. In debug mode, with the option on, a fault raises a breakpoint request in place of the reset.

Software reaches the pointer, the top-of-stack entry and the flags through a small byte-wide register port.

Top module: `retStack`

## Requirements
- R1: After reset the pointer reads 31 (empty), all status flags read 0, every entry holds 0, and `pcResetReq` and `breakReq` are low.
- R2: A push adds one to the 5-bit pointer (31 wraps to 0). It writes `pushPc` into the entry indexed by the new pointer's low four bits. Both take effect at the next clock edge.
- R3: `topPc` always shows the entry indexed by the pointer's low four bits. A pop subtracts one from the pointer, so a pop at pointer 0 leaves 31.
- R4: A push that leaves the pointer's bit 4 set sets the sticky overflow flag, status bit 0.
- R5: A pop while the pointer reads 31 sets the sticky underflow flag, status bit 1.
- R6: With `rstOnFault` high and `debugMode` low, an overflow or underflow does three things. It raises `pcResetReq` for exactly one cycle after the faulting edge, sets the sticky reset-cause flag (status bit 2), and returns the pointer to 31.
- R7: With `rstOnFault` low, a fault raises neither request. The pointer keeps its 5-bit arithmetic, and the index wraps on its low four bits.
- R8: With `rstOnFault` and `debugMode` both high, a fault raises `breakReq` for one cycle. It does not raise `pcResetReq`, does not set the reset-cause flag, and the pointer moves as in R7.
- R9: Register select 0 is the pointer (bits 4:0). Select 1 is entry bits 7:0 and select 2 is entry bits 14:8 on data bits 6:0, both for the entry at the pointer's index. Select 3 is status: bit 0 overflow, bit 1 underflow, bit 2 reset cause. Reads are combinational, and writes take effect at the next edge.
- R10: A write to status clears each flag whose data bit is 1. Flags otherwise hold, and a fault in the same cycle sets its flag anyway.
- R11: When push and pop are requested in the same cycle, only the push is performed.
- R12: A register write in a cycle with a push or pop request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushReq | input | 1 | Push request (call or interrupt) |
| popReq | input | 1 | Pop request (return) |
| pushPc | input | 15 | Address to push |
| topPc | output | 15 | Current top-of-stack entry |
| rstOnFault | input | 1 | Enables the fault reset response |
| debugMode | input | 1 | Turns the fault response into a breakpoint |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| pcResetReq | output | 1 | One-cycle program-counter reset request |
| breakReq | output | 1 | One-cycle breakpoint request |

## Verification
Pointer, entry, flag and request changes all appear one edge after the cycle that asks for them. `topPc` and `regRdData` follow the pointer combinationally within that same cycle. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then reads the results on the next falling edge. For the one-cycle requests it samples again one cycle later to confirm that the pulse has dropped.

// File: rtl/retStackPkg.sv
package retStackPkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic entryWr;
    logic loWr;
    logic hiWr;
  } dataStrobe_t;
endpackage

// File: rtl/retStackData.sv
module retStackData
  import retStackPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 15,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dataStrobe_t      strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [PC_W-1:0]  pushPc,
  input  logic [7:0]       byteData,
  output logic [PC_W-1:0]  rdEntry
);
  localparam int HI_W = PC_W - 8;

  logic [PC_W-1:0] storage [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) storage[i] <= '0;
    end else if (strobe.entryWr) begin
      storage[wrIdx] <= pushPc;
    end else if (strobe.loWr) begin
      storage[wrIdx][7:0] <= byteData;
    end else if (strobe.hiWr) begin
      storage[wrIdx][PC_W-1:8] <= byteData[HI_W-1:0];
    end
  end

  assign rdEntry = storage[rdIdx];

  AST_ENTRY_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.entryWr |=> storage[$past(wrIdx)] == $past(pushPc)); // R2
endmodule

// File: rtl/retStackCtrl.sv
module retStackCtrl
  import retStackPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             rstOnFault,
  input  logic             debugMode,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [7:0]       regWrData,
  output dataStrobe_t      strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [PTR_W-1:0] ptr,
  output logic [2:0]       status,
  output logic             pcResetReq,
  output logic             breakReq
);
  localparam logic [PTR_W-1:0] EMPTY = '1;
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);

  logic stackOp, doPush, doPop, swWr;
  logic [PTR_W-1:0] ptrInc, ptrDec;
  logic ovfEv, unfEv, fault, takeReset, takeBreak;
  logic ovfFlag, unfFlag, causeFlag;
  logic [2:0] clrMask;

  assign stackOp   = pushReq | popReq;
  assign doPush    = pushReq;
  assign doPop     = popReq & ~pushReq;
  assign swWr      = regWrEn & ~stackOp;
  assign ptrInc    = ptr + PTR_W'(1);
  assign ptrDec    = ptr - PTR_W'(1);
  assign ovfEv     = doPush & ptrInc[PTR_W-1];
  assign unfEv     = doPop & (ptr == EMPTY);
  assign fault     = ovfEv | unfEv;
  assign takeReset = fault & rstOnFault & ~debugMode;
  assign takeBreak = fault & rstOnFault & debugMode;
  assign clrMask   = (swWr && regSel == SEL_STAT) ? regWrData[2:0] : 3'b000;

  always_comb begin
    strobe.entryWr = doPush;
    strobe.loWr    = swWr && (regSel == SEL_LO);
    strobe.hiWr    = swWr && (regSel == SEL_HI);
    wrIdx          = doPush ? ptrInc[IDX_W-1:0] : ptr[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= EMPTY;
    end else if (takeReset) begin
      ptr <= EMPTY;
    end else if (doPush) begin
      ptr <= ptrInc;
    end else if (doPop) begin
      ptr <= ptrDec;
    end else if (swWr && regSel == SEL_PTR) begin
      ptr <= regWrData[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag    <= 1'b0;
      unfFlag    <= 1'b0;
      causeFlag  <= 1'b0;
      pcResetReq <= 1'b0;
      breakReq   <= 1'b0;
    end else begin
      ovfFlag    <= ovfEv | (ovfFlag & ~clrMask[0]);
      unfFlag    <= unfEv | (unfFlag & ~clrMask[1]);
      causeFlag  <= takeReset | (causeFlag & ~clrMask[2]);
      pcResetReq <= takeReset;
      breakReq   <= takeBreak;
    end
  end

  assign status = {causeFlag, unfFlag, ovfFlag};

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !takeReset) |=> ptr == $past(ptr) + PTR_W'(1)); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && !takeReset) |=> ptr == $past(ptr) - PTR_W'(1)); // R3
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && ptr == LAST) |=> ovfFlag); // R4
  AST_UNF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && ptr == EMPTY) |=> unfFlag); // R5
  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    pcResetReq |-> ptr == EMPTY); // R6
  AST_BREAK_NOT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !(pcResetReq && breakReq)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrMask[0]) |=> ovfFlag); // R10
endmodule

// File: rtl/retStack.sv
module retStack
  import retStackPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pushReq,
  input  logic            popReq,
  input  logic [PC_W-1:0] pushPc,
  output logic [PC_W-1:0] topPc,
  input  logic            rstOnFault,
  input  logic            debugMode,
  input  logic            regWrEn,
  input  logic [1:0]      regSel,
  input  logic [7:0]      regWrData,
  output logic [7:0]      regRdData,
  output logic            pcResetReq,
  output logic            breakReq
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int HI_W  = PC_W - 8;

  dataStrobe_t      strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [PTR_W-1:0] ptr;
  logic [2:0]       status;

  retStackCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .rstOnFault(rstOnFault), .debugMode(debugMode),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .strobe(strobe), .wrIdx(wrIdx), .ptr(ptr), .status(status),
    .pcResetReq(pcResetReq), .breakReq(breakReq)
  );

  retStackData #(.DEPTH(DEPTH), .PC_W(PC_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .rdIdx(ptr[IDX_W-1:0]), .pushPc(pushPc), .byteData(regWrData),
    .rdEntry(topPc)
  );

  always_comb begin
    unique case (regSel)
      SEL_PTR:  regRdData = 8'(ptr);
      SEL_LO:   regRdData = topPc[7:0];
      SEL_HI:   regRdData = 8'(topPc[PC_W-1:8]);
      default:  regRdData = {5'b0, status};
    endcase
  end
endmodule

// File: tb/test_retStack.sv
module test_retStack;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0;
  logic [14:0] pushPc = '0;
  logic [14:0] topPc;
  logic rstOnFault = 1'b0, debugMode = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic pcResetReq, breakReq;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  retStack i_retStack (.*);

  // {push, pop, pc[14:0], expPtr[4:0], expTop[14:0]}
  localparam logic [36:0] VEC [8] = '{
    {1'b1, 1'b0, 15'h0100, 5'd0,  15'h0100},
    {1'b1, 1'b0, 15'h0222, 5'd1,  15'h0222},
    {1'b1, 1'b0, 15'h7FFF, 5'd2,  15'h7FFF},
    {1'b0, 1'b1, 15'h0000, 5'd1,  15'h0222},
    {1'b1, 1'b1, 15'h1234, 5'd2,  15'h1234},
    {1'b0, 1'b1, 15'h0000, 5'd1,  15'h0222},
    {1'b0, 1'b1, 15'h0000, 5'd0,  15'h0100},
    {1'b0, 1'b1, 15'h0000, 5'd31, 15'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    pushReq = 0; popReq = 0; regWrEn = 0;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    regWrEn = 1; regSel = sel; regWrData = d;
    step();
    regWrEn = 0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] d);
    regSel = sel;
    #1 d = regRdData;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(2'd0, rd); check("R1 ptr", rd, 8'd31);
    readReg(2'd3, rd); check("R1 status", rd, 8'd0);
    check("R1 top", topPc, 15'h0);
    check("R1 requests", {pcResetReq, breakReq}, 2'b00);

    // Vector walk: R2, R3, R11
    foreach (VEC[i]) begin
      pushReq = VEC[i][36]; popReq = VEC[i][35]; pushPc = VEC[i][34:20];
      step();
      idle();
      readReg(2'd0, rd);
      check("R2/R3/R11 vec ptr", rd, 8'(VEC[i][19:15]));
      check("R2/R3/R11 vec top", topPc, 32'(VEC[i][14:0]));
    end
    readReg(2'd3, rd); check("R5 unflagged walk", rd, 8'd0);

    // R9 register port entry access
    regWrite(2'd0, 8'd5);
    regWrite(2'd1, 8'hAB);
    regWrite(2'd2, 8'h15);
    readReg(2'd0, rd); check("R9 ptr write", rd, 8'd5);
    check("R9 entry", topPc, 15'h15AB);
    readReg(2'd1, rd); check("R9 low read", rd, 8'hAB);
    readReg(2'd2, rd); check("R9 high read", rd, 8'h15);

    // R12 write dropped during a push
    pushReq = 1; pushPc = 15'h0042; regWrEn = 1; regSel = 2'd0; regWrData = 8'd9;
    step(); idle();
    readReg(2'd0, rd); check("R12 write dropped", rd, 8'd6);
    check("R12 push done", topPc, 15'h0042);

    // R4 / R7 overflow with option off
    regWrite(2'd0, 8'd31);
    for (int i = 0; i < 16; i++) begin
      pushReq = 1; pushPc = 15'(16'h0100 + i); step();
    end
    idle();
    readReg(2'd3, rd); check("R4 no ovf at 15", rd, 8'd0);
    pushReq = 1; pushPc = 15'h0110; step(); idle();
    readReg(2'd0, rd); check("R7 ptr 16", rd, 8'd16);
    readReg(2'd3, rd); check("R4 ovf flag", rd, 8'd1);
    check("R7 index wrap", topPc, 15'h0110);
    check("R7 no requests", {pcResetReq, breakReq}, 2'b00);
    popReq = 1; step(); idle();
    readReg(2'd0, rd); check("R3 pop from 16", rd, 8'd15);
    check("R3 top after pop", topPc, 15'h010F);

    // R10 sticky and write-one-to-clear
    regWrite(2'd3, 8'h00);
    readReg(2'd3, rd); check("R10 zero write keeps", rd, 8'd1);
    regWrite(2'd3, 8'h01);
    readReg(2'd3, rd); check("R10 clear", rd, 8'd0);

    // R5 / R6 underflow with reset option
    rstOnFault = 1;
    regWrite(2'd0, 8'd31);
    popReq = 1; step(); idle();
    check("R6 reset pulse", {pcResetReq, breakReq}, 2'b10);
    readReg(2'd3, rd); check("R5/R6 status", rd, 8'h06);
    readReg(2'd0, rd); check("R6 ptr empty", rd, 8'd31);
    step();
    check("R6 pulse one cycle", pcResetReq, 1'b0);

    // R6 overflow with reset option
    regWrite(2'd3, 8'h07);
    regWrite(2'd0, 8'd15);
    pushReq = 1; pushPc = 15'h0001; step(); idle();
    check("R6 ovf reset pulse", pcResetReq, 1'b1);
    readReg(2'd0, rd); check("R6 ovf ptr empty", rd, 8'd31);
    readReg(2'd3, rd); check("R4/R6 ovf status", rd, 8'h05);

    // R8 debug breakpoint
    regWrite(2'd3, 8'h07);
    debugMode = 1;
    popReq = 1; step(); idle();
    check("R8 break pulse", {pcResetReq, breakReq}, 2'b01);
    readReg(2'd0, rd); check("R8 ptr continues", rd, 8'd30);
    readReg(2'd3, rd); check("R8 no cause", rd, 8'h02);
    step();
    check("R8 pulse one cycle", breakReq, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule